// File: doc/BRIEF.md
# Low-Power Wakeup Controller

This block sits in the always-on domain of a device and watches for reasons to leave a low-power state. There are three sources. One is activity on a USB data line. The other two are general-purpose wakeup pins, and each pin has a programmable active level. All three inputs are asynchronous. Each is synchronized, and each is compared with its level from the previous cycle to find transitions.

Software sets the controller up through one 8-bit control/status register. The register holds an enable for each source, a polarity select for each pin, and a sticky status flag for each pin. A status flag is cleared by writing 1 to it.

While the device is in low power, a qualified event raises an oscillator-restart request. The block then waits for the clock-stable indication. Only after that does it set a dedicated interrupt flag. The flag is gated by its own enable and stays set until software clears it. A wakeup that leaves both pin status flags clear was caused by data-line activity.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: After reset the register reads 0x05, and the restart request, the interrupt flag and the interrupt output are all 0.
- R2: The register layout is as follows. Bit 7 is the pin-2 status and bit 6 is the pin-1 status. Bit 5 is the pin-2 polarity and bit 4 is the pin-1 polarity. Bit 3 always reads 0. Bit 2 is the data-line enable, bit 1 is the pin-2 enable and bit 0 is the pin-1 enable. Bits 5, 4, 2, 1 and 0 read back the value last written to them.
- R3: A polarity bit of 1 makes its pin active high, and 0 makes it active low. A pin causes an event only on a change from its deasserted level to its asserted level. Holding the pin at its asserted level causes nothing further.
- R4: A source whose enable bit is 0 sets no status flag and raises no restart request.
- R5: A qualified pin event sets that pin's status bit 3 clock edges after the pin changes. A qualified event on the data line is any change of its level. Such an event raises the restart request and sets neither status bit.
- R6: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R7: If a status bit is set and cleared by software on the same edge, it ends up set.
- R8: A qualified event while lowpwr_i is 1 raises osc_restart_o. The request stays high until clk_stable_i is sampled high. On that edge the request drops and irq_flag_o is set. The flag is never set before the clock-stable indication arrives.
- R9: irq_flag_o stays set until irq_clr_i is sampled high. irq_o equals irq_flag_o AND irq_en_i.
- R10: A qualified event while lowpwr_i is 0 still sets the pin status bit but raises no restart request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| lowpwr_i | input | 1 | Device is in its low-power state |
| line_i | input | 1 | USB data-line level, asynchronous |
| pin1_i | input | 1 | Wakeup pin 1, asynchronous |
| pin2_i | input | 1 | Wakeup pin 2, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| osc_restart_o | output | 1 | Oscillator-restart request |
| clk_stable_i | input | 1 | Restarted clock is stable (synchronous) |
| irq_en_i | input | 1 | Wakeup interrupt enable |
| irq_clr_i | input | 1 | Clears the wakeup interrupt flag |
| irq_flag_o | output | 1 | Wakeup interrupt request flag |
| irq_o | output | 1 | Gated wakeup interrupt |

## Verification
The bench writes a status clear on exactly the edge where a pin event lands. A design that lets the clear win would lose that wakeup record. The bench also holds a pin at its asserted level after an event and changes polarity under a steady pin. A level-sensitive design, or one that compares levels under mismatched polarities, would record false wakeups. It waits several cycles with the restart request high before giving the clock-stable pulse, which catches a design that raises the interrupt too early. It also checks that data-line wakeups and disabled sources leave the status bits untouched, and that events outside low power never request an oscillator restart.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
    localparam int          NPIN      = 2;
    localparam int          REG_W     = 8;
    localparam logic [7:0]  REG_RESET = 8'h05;
    localparam logic [7:0]  RW_MASK   = 8'h37;

    typedef struct packed {
        logic [NPIN-1:0] stat;
        logic [NPIN-1:0] pol;
        logic            line_en;
        logic [NPIN-1:0] pin_en;
        logic            pend;
        logic            flag;
    } lpw_state_t;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/lpw_edge.sv
module lpw_edge #(
    parameter int W          = 2,
    parameter bit ANY_CHANGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] ev_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] act_now;
    logic [W-1:0] act_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // normalise both samples with the current polarity so a polarity
    // rewrite under a steady input never looks like a transition
    assign act_now  = lvl_i  ~^ pol_i;
    assign act_prev = prev_q ~^ pol_i;

    generate
        if (ANY_CHANGE) begin : g_any
            assign ev_o = act_now ^ act_prev;
        end else begin : g_rise
            assign ev_o = act_now & ~act_prev;
        end
    endgenerate
endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lowpwr_i,
    input  logic       line_i,
    input  logic       pin1_i,
    input  logic       pin2_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       osc_restart_o,
    input  logic       clk_stable_i,
    input  logic       irq_en_i,
    input  logic       irq_clr_i,
    output logic       irq_flag_o,
    output logic       irq_o
);
    localparam int NSRC = NPIN + 1;

    lpw_state_t       st_d, st_q;
    logic [NSRC-1:0]  raw_sync;
    logic [NPIN-1:0]  pin_ev;
    logic [0:0]       line_ev;
    logic [NPIN-1:0]  pin_qual;
    logic             line_qual;
    logic [7:0]       wr_val;
    logic [NPIN-1:0]  stat_clr;

    lpw_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({line_i, pin2_i, pin1_i}),
        .sync_o (raw_sync)
    );

    lpw_edge #(.W(NPIN), .ANY_CHANGE(1'b0)) u_pin_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (raw_sync[NPIN-1:0]),
        .pol_i (st_q.pol),
        .ev_o  (pin_ev)
    );

    lpw_edge #(.W(1), .ANY_CHANGE(1'b1)) u_line_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (raw_sync[NSRC-1 -: 1]),
        .pol_i (1'b1),
        .ev_o  (line_ev)
    );

    assign pin_qual  = pin_ev & st_q.pin_en;
    assign line_qual = line_ev[0] & st_q.line_en;
    assign wr_val    = reg_wdata_i & RW_MASK;
    assign stat_clr  = reg_wr_i ? reg_wdata_i[7:6] : '0;

    always_comb begin
        st_d = st_q;
        if (reg_wr_i) begin
            st_d.pol     = wr_val[5:4];
            st_d.line_en = wr_val[2];
            st_d.pin_en  = wr_val[1:0];
        end
        // sticky status: a new event outranks a same-cycle clear
        st_d.stat = (st_q.stat & ~stat_clr) | pin_qual;
        st_d.pend = (st_q.pend & ~clk_stable_i)
                  | (lowpwr_i & (|pin_qual | line_qual));
        st_d.flag = (st_q.flag & ~irq_clr_i) | (st_q.pend & clk_stable_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.line_en <= REG_RESET[2];
            st_q.pin_en  <= REG_RESET[1:0];
            st_q.pol     <= REG_RESET[5:4];
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata_o   = {st_q.stat, st_q.pol, 1'b0, st_q.line_en, st_q.pin_en};
    assign osc_restart_o = st_q.pend;
    assign irq_flag_o    = st_q.flag;
    assign irq_o         = st_q.flag & irq_en_i;
endmodule

// File: rtl/lpw_wake_chk.sv
module lpw_wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lowpwr_i,
    input logic       reg_wr_i,
    input logic [1:0] stat_clr,
    input logic [1:0] rdata_stat,
    input logic       rdata_rsvd,
    input logic       osc_restart_o,
    input logic       clk_stable_i,
    input logic       irq_en_i,
    input logic       irq_clr_i,
    input logic       irq_flag_o,
    input logic       irq_o
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_rsvd == 1'b0);

    p_stat2_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_stat[1] && !(reg_wr_i && stat_clr[1])) |=> rdata_stat[1]);

    p_stat1_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_stat[0] && !(reg_wr_i && stat_clr[0])) |=> rdata_stat[0]);

    p_osc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_restart_o && !clk_stable_i) |=> osc_restart_o);

    p_flag_after_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag_o) |-> $past(clk_stable_i && osc_restart_o));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !irq_clr_i) |=> irq_flag_o);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);

    p_no_osc_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_restart_o) |-> $past(lowpwr_i));
endmodule

bind lpw_wake_ctrl lpw_wake_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lowpwr_i     (lowpwr_i),
    .reg_wr_i     (reg_wr_i),
    .stat_clr     (reg_wdata_i[7:6]),
    .rdata_stat   (reg_rdata_o[7:6]),
    .rdata_rsvd   (reg_rdata_o[3]),
    .osc_restart_o(osc_restart_o),
    .clk_stable_i (clk_stable_i),
    .irq_en_i     (irq_en_i),
    .irq_clr_i    (irq_clr_i),
    .irq_flag_o   (irq_flag_o),
    .irq_o        (irq_o)
);

// File: tb/lpw_wake_ctrl_bench.sv
module lpw_wake_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lowpwr_i = 1'b1;
    logic       line_i = 1'b0;
    logic       pin1_i = 1'b1;
    logic       pin2_i = 1'b1;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic       osc_restart_o;
    logic       clk_stable_i = 1'b0;
    logic       irq_en_i = 1'b1;
    logic       irq_clr_i = 1'b0;
    logic       irq_flag_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lpw_wake_ctrl u_lpw_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .lowpwr_i(lowpwr_i), .line_i(line_i),
        .pin1_i(pin1_i), .pin2_i(pin2_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .osc_restart_o(osc_restart_o), .clk_stable_i(clk_stable_i),
        .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
        .irq_flag_o(irq_flag_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] reg_model(logic [1:0] st, logic [1:0] pol,
                                             logic len, logic [1:0] pen);
        return {st, pol, 1'b0, len, pen};
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        reg_wr_i = 1'b1; reg_wdata_i = v;
        tick(1);
        reg_wr_i = 1'b0;
    endtask

    task automatic drain();
        clk_stable_i = 1'b1; tick(1); clk_stable_i = 1'b0;
        irq_clr_i = 1'b1;    tick(1); irq_clr_i = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        if (!done) begin
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 reg", reg_rdata_o, 8'h05);
        check("R1 osc", {7'd0, osc_restart_o}, 8'h0);
        check("R1 flag", {6'd0, irq_flag_o, irq_o}, 8'h0);
        tick(4);
        // R2 writable fields and reserved bit; polarity change under steady pins
        wr(8'hFF);
        check("R2 all ones", reg_rdata_o, 8'h37);
        tick(4);
        check("R3 pol change no event", reg_rdata_o, 8'h37);
        wr(8'h05);
        check("R2 restore", reg_rdata_o, 8'h05);
        tick(4);
        // R3/R5/R8 pin 1 active low falling edge
        pin1_i = 1'b0;
        tick(2);
        check("R5 not yet", reg_rdata_o, 8'h05);
        tick(1);
        check("R5 pin1 status", reg_rdata_o, 8'h45);
        check("R8 osc raised", {7'd0, osc_restart_o}, 8'h1);
        tick(5);
        check("R8 no flag before stable", {7'd0, irq_flag_o}, 8'h0);
        check("R8 osc held", {7'd0, osc_restart_o}, 8'h1);
        clk_stable_i = 1'b1; tick(1); clk_stable_i = 1'b0;
        check("R8 flag on stable", {7'd0, irq_flag_o}, 8'h1);
        check("R8 osc dropped", {7'd0, osc_restart_o}, 8'h0);
        check("R9 irq out", {7'd0, irq_o}, 8'h1);
        irq_en_i = 1'b0; #1;
        check("R9 gated", {7'd0, irq_o}, 8'h0);
        irq_en_i = 1'b1;
        tick(4);
        check("R9 flag sticky", {7'd0, irq_flag_o}, 8'h1);
        irq_clr_i = 1'b1; tick(1); irq_clr_i = 1'b0;
        check("R9 flag cleared", {7'd0, irq_flag_o}, 8'h0);
        // R6 write 1 clears, held level does not re-set (R3)
        wr(8'h45);
        tick(5);
        check("R6 clear / R3 level", reg_rdata_o, 8'h05);
        check("R3 no osc on level", {7'd0, osc_restart_o}, 8'h0);
        pin1_i = 1'b1; tick(3);
        pin1_i = 1'b0; tick(3);
        wr(8'h05);
        check("R6 write 0 keeps", reg_rdata_o, 8'h45);
        drain();
        wr(8'h45);
        // R4 disabled pin 2
        pin2_i = 1'b0; tick(5);
        check("R4 pin2 disabled", reg_rdata_o, 8'h05);
        check("R4 no osc", {7'd0, osc_restart_o}, 8'h0);
        pin2_i = 1'b1; tick(4);
        // R5 data line wakes, sets no status
        line_i = 1'b1; tick(3);
        check("R5 line status", reg_rdata_o, 8'h05);
        check("R5 line osc", {7'd0, osc_restart_o}, 8'h1);
        drain();
        // R4 data line disabled
        wr(8'h01);
        line_i = 1'b0; tick(5);
        check("R4 line disabled", {7'd0, osc_restart_o}, 8'h0);
        // R10 event outside low power
        lowpwr_i = 1'b0;
        pin1_i = 1'b1; tick(3);
        pin1_i = 1'b0; tick(3);
        check("R10 status", reg_rdata_o, 8'h41);
        check("R10 no osc", {7'd0, osc_restart_o}, 8'h0);
        lowpwr_i = 1'b1;
        wr(8'h41);
        // R7 clear and set on same edge
        pin1_i = 1'b1; tick(3);
        pin1_i = 1'b0; tick(2);
        reg_wr_i = 1'b1; reg_wdata_i = 8'h41;
        tick(1);
        reg_wr_i = 1'b0;
        check("R7 set wins", reg_rdata_o, 8'h41);
        drain();
        // R3 active high on pin 2
        wr(8'hE2);
        pin2_i = 1'b0; tick(4);
        check("R3 deassert no event", reg_rdata_o, 8'h22);
        pin2_i = 1'b1; tick(3);
        check("R3 active high", reg_rdata_o, 8'hA2);
        drain();

        // constrained random
        void'($urandom(32'h1F2E3D4C));
        for (int it = 0; it < 60; it++) begin
            int         k;
            logic       pol, en, lp;
            logic [1:0] polv, env, st;
            logic       exp_osc;
            k    = $urandom_range(0, 1);
            pol  = 1'($urandom_range(0, 1));
            en   = 1'($urandom_range(0, 1));
            lp   = 1'($urandom_range(0, 1));
            polv = 2'($urandom_range(0, 3));
            polv[k] = pol;
            env  = 2'b00; env[k] = en;
            if (k == 0) pin1_i = ~pol; else pin2_i = ~pol;
            tick(4);
            wr({2'b11, polv, 1'b0, 1'b0, env});
            tick(2);
            drain();
            lowpwr_i = lp;
            if (k == 0) pin1_i = pol; else pin2_i = pol;
            tick(3);
            st = 2'b00; st[k] = en;
            exp_osc = en & lp;
            check("R3 R4 random reg", reg_rdata_o, reg_model(st, polv, 1'b0, env));
            check("R8 R10 random osc", {7'd0, osc_restart_o}, {7'd0, exp_osc});
            clk_stable_i = 1'b1; tick(1); clk_stable_i = 1'b0;
            check("R8 random flag", {7'd0, irq_flag_o}, {7'd0, exp_osc});
            irq_clr_i = 1'b1; tick(1); irq_clr_i = 1'b0;
            lowpwr_i = 1'b1;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule